// File: doc/BRIEF.md
# External Interrupt Sense Detector

This block watches eight external interrupt pins and turns activity on each of them into a pending-request output. Each pin has its own 2-bit sense mode, held in a 32-bit control register. The four modes are falling edge, rising edge, low level and high level. Every pin first passes through a two-flop synchroniser clocked by the bus clock, so asynchronous pins can be wired straight in.

An edge-sensed request is latched and held until software pulses that pin's clear strobe. A level-sensed request is qualified by requiring the same level on three consecutive synchronised samples. It then follows the pin and drops as soon as the pin leaves the selected level.

A per-pin enable, driven from a separate mode register elsewhere in the chip, marks which pins act as individual interrupts. A pin that is not enabled raises nothing. Priority encoding and vectoring are left to the logic downstream of the request outputs.

Top module: `irq_sense_unit`

## Requirements
- R1: Every field of the control register resets to 00, so `cfg_rdata` reads 0 after reset. A write with `cfg_wr_en` high stores the sense field for pin n in bits [31-2n:30-2n] (pin 0 at 31:30, pin 7 at 17:16), and that value reads back on `cfg_rdata` after the write edge.
- R2: Bits 15:0 of the control register always read 0, whatever value is written to them.
- R3: Field 00 detects falling edges and 01 detects rising edges. If the pin changes before clock edge k, `irq_req` rises after edge k+2: two edges to synchronise, one edge to latch. The opposite edge raises nothing.
- R4: Field 10 requests while the pin is low and field 11 requests while the pin is high. If the pin reaches the selected level before edge k and stays there, `irq_req` rises after edge k+3, that is after three consecutive synchronised samples at that level.
- R5: A level request drops after edge j+1 when the pin leaves the selected level before edge j. A return to the level restarts qualification, so an excursion lasting fewer than three samples raises nothing.
- R6: An edge request stays pending until the pin's `irq_clr` bit is high at a clock edge. If a new qualifying edge is latched on that same edge, the request stays pending.
- R7: While `pin_en[n]` is 0, `irq_req[n]` is 0 in the same cycle. An edge that occurs while the pin is disabled is not latched, and it does not appear after the pin is re-enabled.
- R8: A write that changes a pin's sense field clears that pin's pending edge request and restarts its level qualification. Rewriting the same field value disturbs neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register contents; bits 15:0 are always 0 |
| pin_en | input | 8 | Per-pin enable for individual-interrupt use |
| irq_pin | input | 8 | Raw asynchronous interrupt pins |
| irq_clr | input | 8 | Per-pin clear for latched edge requests |
| irq_req | output | 8 | Per-pin pending request |

## Verification
The bench builds the block with its default parameters: eight pins, 2-bit fields, a 32-bit register, a qualification count of three and two synchroniser stages. This size lets every sense mode run on its own pin at the same time, so a write that changes one field also shows that the other pins are left alone. The small qualification count makes the exact edge on which a level request rises reachable in a few cycles. It also makes a sub-threshold excursion easy to provoke. The checks aim at exact cycle boundaries: the edge a request first appears, a clear colliding with a new edge, re-enabling after a masked edge, and a mode rewrite that leaves the value unchanged.

// File: rtl/irq_sense_pkg.sv
`timescale 1ns/1ps
package irq_sense_pkg;

  typedef enum logic [1:0] {
    SENSE_FALL = 2'b00,
    SENSE_RISE = 2'b01,
    SENSE_LOW  = 2'b10,
    SENSE_HIGH = 2'b11
  } sense_e;

  // lowest bit of the field that belongs to pin n (pin 0 at the top)
  function automatic int field_lsb(input int n, input int fw, input int rw);
    return rw - fw * (n + 1);
  endfunction

  // ones over every implemented field, zeros over the reserved tail
  function automatic logic [63:0] field_mask(input int np, input int fw, input int rw);
    logic [63:0] m;
    m = '0;
    for (int b = 0; b < 64; b++) begin
      if (b < rw && b >= rw - np * fw) m[b] = 1'b1;
    end
    return m;
  endfunction

  // a run of matching samples is long enough once it reaches qual-1 prior hits
  function automatic logic run_qualified(input int run, input int qual);
    return run >= qual - 1;
  endfunction

endpackage

// File: rtl/irq_sense_cfg.sv
`timescale 1ns/1ps
module irq_sense_cfg #(
  parameter int NPINS   = 8,
  parameter int FIELD_W = 2,
  parameter int REG_W   = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [REG_W-1:0]               wdata,
  output logic [REG_W-1:0]               rdata,
  output logic [NPINS-1:0][FIELD_W-1:0]  modes,
  output logic [NPINS-1:0]               mode_chg
);
  localparam int RSVD_W = REG_W - NPINS * FIELD_W;
  localparam logic [REG_W-1:0] MASK =
    REG_W'(irq_sense_pkg::field_mask(NPINS, FIELD_W, REG_W));

  logic [REG_W-1:0] reg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     reg_q <= '0;
    else if (wr_en) reg_q <= wdata & MASK;
  end

  assign rdata = reg_q;

  for (genvar g = 0; g < NPINS; g++) begin : g_field
    localparam int LSB = irq_sense_pkg::field_lsb(g, FIELD_W, REG_W);
    assign modes[g]    = reg_q[LSB +: FIELD_W];
    assign mode_chg[g] = wr_en && (wdata[LSB +: FIELD_W] != reg_q[LSB +: FIELD_W]);
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[RSVD_W-1:0] == '0); // R2
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rdata[REG_W-1:RSVD_W] == $past(wdata[REG_W-1:RSVD_W])); // R1

endmodule

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
module irq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/irq_pin_detect.sv
`timescale 1ns/1ps
module irq_pin_detect #(
  parameter int QUAL = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp,
  input  logic [1:0] mode,
  input  logic       mode_chg,
  input  logic       en,
  input  logic       clr,
  output logic       req
);
  import irq_sense_pkg::*;

  localparam int CNT_W = (QUAL > 2) ? $clog2(QUAL) : 1;
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(QUAL - 1);

  sense_e           sense;
  logic             prev_q;
  logic             edge_pend;
  logic [CNT_W-1:0] run_q;

  // named internal events
  logic rise_ev, fall_ev, edge_hit, lvl_mode, lvl_match, lvl_ok;

  assign sense     = sense_e'(mode);
  assign rise_ev   = smp && !prev_q;
  assign fall_ev   = !smp && prev_q;
  assign edge_hit  = en && (((sense == SENSE_RISE) && rise_ev) ||
                            ((sense == SENSE_FALL) && fall_ev));
  assign lvl_mode  = (sense == SENSE_LOW) || (sense == SENSE_HIGH);
  assign lvl_match = (smp == (sense == SENSE_HIGH));
  assign lvl_ok    = lvl_mode && lvl_match && run_qualified(int'(run_q), QUAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= smp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        edge_pend <= 1'b0;
    else if (mode_chg) edge_pend <= 1'b0;
    else if (edge_hit) edge_pend <= 1'b1;
    else if (clr)      edge_pend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         run_q <= '0;
    else if (mode_chg || !lvl_match)    run_q <= '0;
    else if (run_q < RUN_MAX)           run_q <= run_q + 1'b1;
  end

  assign req = en && (edge_pend || lvl_ok);

  AST_LVL_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_ok |-> (lvl_match && $past(lvl_match) && $past(lvl_match, 2))); // R4
  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_pend && !clr && !mode_chg) |=> edge_pend); // R6
  AST_CHG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (!edge_pend && run_q == '0)); // R8
  AST_MASKED_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(edge_pend) |-> $past(en)); // R7
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !edge_hit) |=> !edge_pend); // R6

endmodule

// File: rtl/irq_sense_unit.sv
`timescale 1ns/1ps
module irq_sense_unit #(
  parameter int NPINS       = 8,
  parameter int FIELD_W     = 2,
  parameter int REG_W       = 32,
  parameter int QUAL        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic [NPINS-1:0] pin_en,
  input  logic [NPINS-1:0] irq_pin,
  input  logic [NPINS-1:0] irq_clr,
  output logic [NPINS-1:0] irq_req
);
  logic [NPINS-1:0][FIELD_W-1:0] modes;
  logic [NPINS-1:0]              mode_chg;
  logic [NPINS-1:0]              pin_smp;

  irq_sense_cfg #(.NPINS(NPINS), .FIELD_W(FIELD_W), .REG_W(REG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .modes(modes), .mode_chg(mode_chg)
  );

  irq_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_pin), .q(pin_smp)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    irq_pin_detect #(.QUAL(QUAL)) u_det (
      .clk(clk), .rst_n(rst_n), .smp(pin_smp[g]), .mode(modes[g][1:0]),
      .mode_chg(mode_chg[g]), .en(pin_en[g]), .clr(irq_clr[g]),
      .req(irq_req[g])
    );
  end

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_en[0] && $past(!pin_en[0])) |-> !irq_req[0]); // R7

endmodule

// File: tb/irq_sense_unit_tb_top.sv
`timescale 1ns/1ps
module irq_sense_unit_tb_top;
  localparam real CLK_HALF = 4.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [7:0]  pin_en = 8'hFF;
  logic [7:0]  irq_pin = '0;
  logic [7:0]  irq_clr = '0;
  logic [7:0]  irq_req;

  int checks = 0;
  int failures = 0;

  always #(CLK_HALF) clk = ~clk;

  irq_sense_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pin_en(pin_en), .irq_pin(irq_pin),
    .irq_clr(irq_clr), .irq_req(irq_req)
  );

  // {write value, expected read value}
  localparam logic [63:0] REG_VEC [0:3] = '{
    {32'hFFFF_FFFF, 32'hFFFF_0000},
    {32'h1234_5678, 32'h1234_0000},
    {32'hA5C3_0F0F, 32'hA5C3_0000},
    {32'h0000_FFFF, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic pulse_clr(input int p);
    irq_clr[p] = 1'b1;
    step(1);
    irq_clr[p] = 1'b0;
  endtask

  initial begin
    #(CLK_HALF * 2.0 * 200000.0);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic seen;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 reset rdata", cfg_rdata, 32'h0);
    chk("R1 reset req", {24'h0, irq_req}, 32'h0);

    for (int i = 0; i < 4; i++) begin
      wr_cfg(REG_VEC[i][63:32]);
      chk("R1 R2 register vector", cfg_rdata, REG_VEC[i][31:0]);
    end

    // R3 rising edge on pin 0
    wr_cfg(32'h5555_0000);
    irq_pin[0] = 1'b1;
    step(2); chk("R3 rise not yet", 32'(irq_req[0]), 32'h0);
    step(1); chk("R3 rise latched", 32'(irq_req[0]), 32'h1);
    irq_pin[0] = 1'b0;
    step(4); chk("R6 edge held", 32'(irq_req[0]), 32'h1);
    pulse_clr(0); chk("R6 clear", 32'(irq_req[0]), 32'h0);

    // R3 falling edge on pin 1
    wr_cfg(32'h4555_0000);
    irq_pin[1] = 1'b1;
    step(4); chk("R3 opposite edge ignored", 32'(irq_req[1]), 32'h0);
    irq_pin[1] = 1'b0;
    step(2); chk("R3 fall not yet", 32'(irq_req[1]), 32'h0);
    step(1); chk("R3 fall latched", 32'(irq_req[1]), 32'h1);
    pulse_clr(1);

    // R6 clear colliding with a new edge on pin 2
    irq_pin[2] = 1'b1;
    step(3); chk("R6 pin2 latched", 32'(irq_req[2]), 32'h1);
    irq_pin[2] = 1'b0;
    step(3);
    irq_pin[2] = 1'b1;
    step(2);
    pulse_clr(2);
    chk("R6 clear with new edge", 32'(irq_req[2]), 32'h1);
    pulse_clr(2);
    chk("R6 later clear", 32'(irq_req[2]), 32'h0);

    // R4 low level on pin 3 (pin already low)
    wr_cfg(32'h4655_0000);
    chk("R4 low after write", 32'(irq_req[3]), 32'h0);
    step(1); chk("R4 low two samples", 32'(irq_req[3]), 32'h0);
    step(1); chk("R4 low qualified", 32'(irq_req[3]), 32'h1);
    irq_pin[3] = 1'b1;
    step(1); chk("R5 still low inside", 32'(irq_req[3]), 32'h1);
    step(1); chk("R5 level left", 32'(irq_req[3]), 32'h0);
    irq_pin[3] = 1'b0;
    step(1);
    irq_pin[3] = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step(1);
      seen = seen | irq_req[3];
    end
    chk("R5 short excursion", 32'(seen), 32'h0);
    irq_pin[3] = 1'b0;
    step(3); chk("R5 requalify not yet", 32'(irq_req[3]), 32'h0);
    step(1); chk("R4 requalified", 32'(irq_req[3]), 32'h1);

    // R4 high level on pin 4
    wr_cfg(32'h46D5_0000);
    irq_pin[4] = 1'b1;
    step(3); chk("R4 high not yet", 32'(irq_req[4]), 32'h0);
    step(1); chk("R4 high qualified", 32'(irq_req[4]), 32'h1);

    // R7 enable gating
    pin_en[4] = 1'b0;
    #1 chk("R7 level masked", 32'(irq_req[4]), 32'h0);
    pin_en[5] = 1'b0;
    irq_pin[5] = 1'b1;
    step(4); chk("R7 masked edge", 32'(irq_req[5]), 32'h0);
    pin_en[5] = 1'b1;
    #1 chk("R7 masked edge not latched", 32'(irq_req[5]), 32'h0);
    pin_en[4] = 1'b1;
    #1 chk("R7 level back", 32'(irq_req[4]), 32'h1);

    // R8 mode rewrite on pin 6
    step(1);
    irq_pin[6] = 1'b1;
    step(3); chk("R8 pin6 latched", 32'(irq_req[6]), 32'h1);
    wr_cfg(32'h46D5_0000);
    chk("R8 same value keeps", 32'(irq_req[6]), 32'h1);
    wr_cfg(32'h46DD_0000);
    chk("R8 change clears", 32'(irq_req[6]), 32'h0);
    step(1); chk("R8 requalify not yet", 32'(irq_req[6]), 32'h0);
    step(1); chk("R8 requalified", 32'(irq_req[6]), 32'h1);
    chk("R1 final rdata", cfg_rdata, 32'h46DD_0000);
    chk("R3 idle pin7", 32'(irq_req[7]), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule